// File: doc/BRIEF.md
# Fifteen-Cent Coin Credit Controller

This block is the credit tracker behind a single-item dispenser that costs 15 cents. A coin sensor sends it one clock-wide pulse per coin on one of two lines: one for a 5-cent coin and one for a 10-cent coin. The block adds up the credit and raises a release level once the credit reaches the price. It never gives change. Any overpayment is simply absorbed: credit saturates at the price.

The controller is a Moore machine with four named states:

- `CR_ZERO` (no credit, encoding 00)
- `CR_FIVE` (5 cents, 01)
- `CR_TEN` (10 cents, 10)
- `CR_PAID` (15 cents or more, 11)

The transitions are:

- A nickel moves `CR_ZERO`→`CR_FIVE`, `CR_FIVE`→`CR_TEN` and `CR_TEN`→`CR_PAID`.
- A dime moves `CR_ZERO`→`CR_TEN`, `CR_FIVE`→`CR_PAID` and `CR_TEN`→`CR_PAID`.
- With no coin, each of the first three states holds.
- `CR_PAID` holds whatever the inputs are.
- Synchronous reset returns any state to `CR_ZERO`.

The release output is high only in `CR_PAID`, so it stays high until reset. Both coin lines pulsing in the same cycle cannot happen with a correct sensor. The block resolves that case as a dime and records it in a sticky clash flag, which only reset clears. The parameter `REG_OUT` adds one register stage on the release output.

Top module: `vend_ctrl`

## Requirements
- R1: A cycle with `rst` high puts the block in `CR_ZERO`. After that edge, `release_o` is 0 and `clash_o` is 0.
- R2: In `CR_ZERO`, `CR_FIVE` and `CR_TEN`, a cycle with neither coin line high leaves the credit unchanged.
- R3: A nickel pulse alone moves `CR_ZERO`→`CR_FIVE`, `CR_FIVE`→`CR_TEN` and `CR_TEN`→`CR_PAID`.
- R4: A dime pulse moves `CR_ZERO`→`CR_TEN`, `CR_FIVE`→`CR_PAID` and `CR_TEN`→`CR_PAID`. Credit above 15 cents is absorbed into `CR_PAID`.
- R5: With `REG_OUT`=0, `release_o` is 1 exactly when the state is `CR_PAID`. It rises on the clock edge that registers the final coin.
- R6: `CR_PAID` holds under any coin input until reset, and `release_o` stays 1 throughout.
- R7: Both coin lines high in one cycle are taken as a dime. They also set `clash_o` on that edge. `clash_o` then stays 1 until reset.
- R8: With `REG_OUT`=1, `release_o` follows the paid state one clock later than with `REG_OUT`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| nickel_i | input | 1 | One-cycle pulse per 5-cent coin |
| dime_i | input | 1 | One-cycle pulse per 10-cent coin |
| release_o | output | 1 | Dispense level, high once paid until reset |
| clash_o | output | 1 | Sticky flag: both coin lines seen together |

## Verification
The credit held in `CR_FIVE` and `CR_TEN` never appears at a port. The bench proves it indirectly: it lets the block idle for several cycles and then checks that exactly the expected number of extra nickels raises the release. The clash case needs both coin lines driven in the same cycle. The bench forces this from both `CR_ZERO` and `CR_FIVE`, then completes the purchase, which shows the pair was counted as a dime. Every coin order that reaches the price is run on two instances, one for each `REG_OUT` setting. This exposes the extra cycle of latency on the registered variant.

// File: rtl/vend_pkg.sv
package vend_pkg;
    typedef enum logic [1:0] {
        CR_ZERO = 2'b00,
        CR_FIVE = 2'b01,
        CR_TEN  = 2'b10,
        CR_PAID = 2'b11
    } credit_e;
endpackage

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    nickel_i,
    input  logic    dime_i,
    output credit_e state_o
);
    credit_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CR_ZERO;
        else     state_q <= state_d;
    end

    // next-state logic; both lines together resolve as a dime
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CR_ZERO: begin
                if (dime_i)        state_d = CR_TEN;
                else if (nickel_i) state_d = CR_FIVE;
            end
            CR_FIVE: begin
                if (dime_i)        state_d = CR_PAID;
                else if (nickel_i) state_d = CR_TEN;
            end
            CR_TEN: begin
                if (dime_i || nickel_i) state_d = CR_PAID;
            end
            CR_PAID: state_d = CR_PAID;
        endcase
    end

    assign state_o = state_q;

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> state_q == CR_ZERO);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!nickel_i && !dime_i && state_q != CR_PAID) |=> $stable(state_q));
    p_nickel_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == CR_ZERO && nickel_i && !dime_i) |=> state_q == CR_FIVE);
    p_nickel_five_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == CR_FIVE && nickel_i && !dime_i) |=> state_q == CR_TEN);
    p_nickel_ten_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == CR_TEN && nickel_i && !dime_i) |=> state_q == CR_PAID);
    p_dime_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == CR_ZERO && dime_i) |=> state_q == CR_TEN);
    p_dime_sat_r4: assert property (@(posedge clk) disable iff (rst)
        ((state_q == CR_FIVE || state_q == CR_TEN) && dime_i) |=> state_q == CR_PAID);
    p_paid_hold_r6: assert property (@(posedge clk) disable iff (rst)
        state_q == CR_PAID |=> state_q == CR_PAID);
endmodule

// File: rtl/vend_clash_flag.sv
module vend_clash_flag (
    input  logic clk,
    input  logic rst,
    input  logic nickel_i,
    input  logic dime_i,
    output logic clash_o
);
    logic clash_q;

    always_ff @(posedge clk) begin
        if (rst)                      clash_q <= 1'b0;
        else if (nickel_i && dime_i)  clash_q <= 1'b1;
    end

    assign clash_o = clash_q;

    p_clash_set_r7: assert property (@(posedge clk) disable iff (rst)
        (nickel_i && dime_i) |=> clash_q);
    p_clash_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        clash_q |=> clash_q);
    p_clash_reset_r1: assert property (@(posedge clk) rst |=> !clash_q);
endmodule

// File: rtl/vend_release_stage.sv
module vend_release_stage #(
    parameter bit REG_OUT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic paid_i,
    output logic release_o
);
    generate
        if (REG_OUT) begin : g_reg
            logic release_q;
            always_ff @(posedge clk) begin
                if (rst) release_q <= 1'b0;
                else     release_q <= paid_i;
            end
            assign release_o = release_q;

            p_reg_lag_r8: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> release_o == $past(paid_i));
        end else begin : g_comb
            assign release_o = paid_i;
        end
    endgenerate
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter bit REG_OUT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic nickel_i,
    input  logic dime_i,
    output logic release_o,
    output logic clash_o
);
    credit_e state;
    logic    paid;

    vend_credit_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .state_o  (state)
    );

    // Moore output decode
    always_comb begin
        unique case (state)
            CR_PAID: paid = 1'b1;
            default: paid = 1'b0;
        endcase
    end

    vend_clash_flag u_clash (
        .clk      (clk),
        .rst      (rst),
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .clash_o  (clash_o)
    );

    vend_release_stage #(.REG_OUT(REG_OUT)) u_rel (
        .clk       (clk),
        .rst       (rst),
        .paid_i    (paid),
        .release_o (release_o)
    );

    p_release_stays_r6: assert property (@(posedge clk) disable iff (rst)
        release_o |=> release_o);
    p_release_reset_r1: assert property (@(posedge clk) rst |=> !release_o);

    generate
        if (!REG_OUT) begin : g_chk_comb
            p_release_on_coin_r5: assert property (@(posedge clk) disable iff (rst)
                (!release_o && !nickel_i && !dime_i) |=> !release_o);
        end
    endgenerate
endmodule

// File: tb/test_vend_ctrl.sv
`timescale 1ns/1ps
module test_vend_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel = 1'b0;
    logic dime = 1'b0;
    logic rel, clash, rel_r, clash_r;
    int   n_checks = 0;
    int   n_fail = 0;

    always #2 clk = ~clk;

    vend_ctrl #(.REG_OUT(1'b0)) i_vend_ctrl (
        .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime),
        .release_o(rel), .clash_o(clash));

    vend_ctrl #(.REG_OUT(1'b1)) i_vend_ctrl_reg (
        .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime),
        .release_o(rel_r), .clash_o(clash_r));

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // one cycle of inputs, returns at the negedge after the registering edge
    task automatic apply(input logic n, input logic d);
        nickel = n;
        dime = d;
        @(negedge clk);
        nickel = 1'b0;
        dime = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "release after reset", rel, 1'b0);
        check("R1", "clash after reset", clash, 1'b0);
        check("R1", "reg release after reset", rel_r, 1'b0);
    endtask

    // seq bit i: 1 = dime, 0 = nickel; coin count len
    task automatic pay_seq(input int len, input logic [3:0] seq, input string tag);
        do_reset();
        for (int i = 0; i < len; i++) begin
            apply(~seq[i], seq[i]);
            if (i < len - 1)
                check(seq[i] ? "R4" : "R3", {tag, " early release"}, rel, 1'b0);
        end
        check("R5", {tag, " release on final coin"}, rel, 1'b1);
        check("R8", {tag, " reg release still low"}, rel_r, 1'b0);
        @(negedge clk);
        check("R8", {tag, " reg release one cycle later"}, rel_r, 1'b1);
        apply(1'b1, 1'b0);
        apply(1'b0, 1'b1);
        repeat (3) @(negedge clk);
        check("R6", {tag, " release held under coins"}, rel, 1'b1);
        check("R6", {tag, " reg release held"}, rel_r, 1'b1);
    endtask

    task automatic test_idle_hold();
        do_reset();
        repeat (4) @(negedge clk);
        check("R2", "idle zero", rel, 1'b0);
        apply(1'b1, 1'b0);
        repeat (6) @(negedge clk);
        check("R2", "hold five", rel, 1'b0);
        apply(1'b1, 1'b0);
        repeat (6) @(negedge clk);
        check("R2", "hold ten", rel, 1'b0);
        apply(1'b1, 1'b0);
        check("R3", "third nickel pays", rel, 1'b1);
    endtask

    task automatic test_clash();
        do_reset();
        apply(1'b1, 1'b1);
        check("R7", "clash set", clash, 1'b1);
        check("R7", "pair alone not paid", rel, 1'b0);
        apply(1'b1, 1'b0);
        check("R7", "pair counted as dime", rel, 1'b1);
        repeat (5) @(negedge clk);
        check("R7", "clash sticky", clash, 1'b1);
        do_reset();
        check("R1", "clash cleared", clash, 1'b0);
        apply(1'b1, 1'b0);
        apply(1'b1, 1'b1);
        check("R7", "five plus pair pays", rel, 1'b1);
        check("R7", "clash set from five", clash, 1'b1);
        do_reset();
        apply(1'b1, 1'b0);
        check("R7", "single coin no clash", clash, 1'b0);
    endtask

    task automatic test_reset_from_paid();
        do_reset();
        apply(1'b0, 1'b1);
        apply(1'b0, 1'b1);
        check("R4", "two dimes pay", rel, 1'b1);
        do_reset();
        apply(1'b0, 1'b1);
        check("R1", "reset returned to zero", rel, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        do_reset();
        pay_seq(3, 4'b0000, "NNN");
        pay_seq(3, 4'b0100, "NND");
        pay_seq(2, 4'b0010, "ND");
        pay_seq(2, 4'b0001, "DN");
        pay_seq(2, 4'b0011, "DD");
        test_idle_hold();
        test_clash();
        test_reset_from_paid();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule